// File: doc/BRIEF.md
# Static Memory Chip-Select Timing Controller

This block runs one chip-select channel of an external static memory, such as an SRAM or a NOR flash. An internal requester places a single read or write on a request port. The block then produces the chip select, output enable, write enable and byte-lane strobes with programmable timing. It returns read data and a one-cycle acknowledge when the access is finished. Every access is a single beat on an 8-, 16- or 32-bit device. The block never splits an access across several device cycles.

The timing inputs are static configuration that the surrounding logic holds steady while accesses run. They set how long each phase lasts, the chip-select polarity and the byte-strobe signalling style. They also switch on page mode, which shortens follow-on reads to the same four-word group. Finally, they switch on extended wait, in which an active-low wait input from the device stretches the access until a programmable timeout.

A request is taken in the cycle it is presented, provided the controller is idle or at the end of its turnaround gap. The requester raises `req_valid` for that one cycle. Chip select goes active on the following cycle. `req_ack` pulses in the first cycle after chip select goes inactive, and `rsp_rdata` and `rsp_timeout` are valid in that same cycle.

Top module: `smc_static_ctl`

## Requirements
- R1: After reset and whenever no access runs, chip select is at its inactive level, `mem_oe_n`, `mem_we_n` and every bit of `mem_bls` are 1, and `req_ack` is 0.
- R2: With `cfg_cs_high`=0 chip select is driven low during an access and high otherwise. With `cfg_cs_high`=1 the levels are swapped.
- R3: A read that is not in-page keeps chip select active for `cfg_rd_wait`+1 cycles. `mem_oe_n` goes low `cfg_oe_dly` cycles after the first chip-select cycle and stays low until chip select ends. `mem_we_n` stays high.
- R4: A write keeps chip select active for `cfg_wr_wait`+2 cycles. `mem_we_n` goes low `cfg_we_dly`+1 cycles after the first chip-select cycle and stays low until chip select ends. `mem_dout` carries the request data with `mem_dout_en`=1.
- R5: With `cfg_page_en`=1, a read is in-page when the previous accepted access was a read and both word addresses agree in every bit above bit 1. An in-page read keeps chip select active for `cfg_pg_wait`+1 cycles.
- R6: A write, a read to another four-word group, or `cfg_page_en`=0 makes the next read a full `cfg_rd_wait`+1 access.
- R7: When a new request is presented in the acknowledge cycle, chip select stays inactive for exactly `cfg_turn`+1 cycles between the two accesses.
- R8: Strobe style `cfg_strobe_low`=0 drives the active lanes of a read at 1 and the other lanes at 0. It drives the active lanes of a write at 0 and the other lanes at 1. Style 1 drives active lanes at 0 and the other lanes at 1 for both reads and writes.
- R9: Width code `cfg_width` 0 gives lane 0 only (8 bits), 1 gives lanes 0..1, 2 gives lanes 0..3, and 3 gives no lane. A write additionally enables only the lanes whose `req_be` bit is 1.
- R10: `req_ack` is a single-cycle pulse. In that cycle `rsp_rdata` holds the device data of the lanes inside the width, sampled in the last chip-select cycle, with the lanes outside the width zero.
- R11: With `cfg_ext_wait`=1, the access holds its last cycle while `mem_wait_n` is 0 and ends in the first last-phase cycle in which `mem_wait_n` is 1. `rsp_timeout` is then 0.
- R12: If `mem_wait_n` stays 0, the access ends after 16*(`cfg_tmo`+1) held cycles plus the final cycle, so chip select lasts the normal length plus 16*(`cfg_tmo`+1) cycles, and `rsp_timeout` is 1 in the acknowledge cycle.
- R13: With `cfg_ext_wait`=0, `mem_wait_n` has no effect on access length or on `rsp_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cs_high | input | 1 | Chip-select polarity, 1 = active high |
| cfg_strobe_low | input | 1 | Byte-strobe style (R8) |
| cfg_page_en | input | 1 | Enable page-mode fast reads |
| cfg_ext_wait | input | 1 | Enable wait-input stretching |
| cfg_width | input | 2 | Device width code (R9) |
| cfg_we_dly | input | DLY_W | Write-enable delay field |
| cfg_oe_dly | input | DLY_W | Output-enable delay field |
| cfg_rd_wait | input | WS_W | Full read wait states |
| cfg_pg_wait | input | WS_W | In-page read wait states |
| cfg_wr_wait | input | WS_W | Write wait states |
| cfg_turn | input | DLY_W | Turnaround field |
| cfg_tmo | input | TMO_W | Extended-wait timeout field |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Write byte enables |
| req_ack | output | 1 | Completion pulse |
| rsp_rdata | output | DW | Read data |
| rsp_timeout | output | 1 | Access ended by timeout |
| mem_addr | output | AW | Device address |
| mem_cs | output | 1 | Chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls | output | DW/8 | Byte-lane strobes |
| mem_dout | output | DW | Write data to device |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DW | Data from device |
| mem_wait_n | input | 1 | Device wait, active low |

## Verification
Each phase length carries its own offset: n for output enable, n+1 for write enable, full reads and turnaround, and n+2 for writes. The bench measures every length at zero and non-zero fields. A design that shared one offset across phases, or that counted from the request rather than from chip select, would be off by a cycle.

Page detection is driven through a sequence that mixes in-page hits, a write, a neighbouring four-word group and page mode switched off. A design that compared the whole address, or that kept the page open across a write, would give wrong access lengths.

The wait input is tested three ways: released mid-stretch, held to timeout at two field values, and held low with stretching disabled. These catch a timeout that is off by sixteen and a wait input that leaks through when stretching is off.

The strobes are checked for each width code, including the reserved one, in both signalling styles and with partial byte enables. This exposes inverted levels and lanes enabled outside the device width.

// File: rtl/smc_pkg.sv
package smc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_TURN = 2'd2
    } smc_state_e;

    localparam logic [1:0] WIDTH_8  = 2'd0;
    localparam logic [1:0] WIDTH_16 = 2'd1;
    localparam logic [1:0] WIDTH_32 = 2'd2;
endpackage

// File: rtl/smc_lane_map.sv
module smc_lane_map
    import smc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [1:0]         width,
    input  logic               is_write,
    input  logic               strobe_low,
    input  logic               active,
    input  logic [LANES-1:0]   be,
    input  logic [8*LANES-1:0] din,
    output logic [LANES-1:0]   bls,
    output logic [8*LANES-1:0] rd_lanes
);
    int   n_on;
    logic level_on;

    always_comb begin
        case (width)
            WIDTH_8:  n_on = 1;
            WIDTH_16: n_on = 2;
            WIDTH_32: n_on = 4;
            default:  n_on = 0;
        endcase
    end

    // reads in style 0 assert high; everything else asserts low
    assign level_on = !strobe_low && !is_write;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic in_width;
        logic lane_on;
        assign in_width = (n_on > i);
        assign lane_on  = in_width && (!is_write || be[i]);
        assign bls[i]   = active ? (lane_on ? level_on : !level_on) : 1'b1;
        assign rd_lanes[8*i +: 8] = in_width ? din[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/smc_page_track.sv
module smc_page_track #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          page_en,
    input  logic          accept,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    output logic          hit
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
    } trk_t;

    trk_t d, q;

    assign hit = page_en && !req_write && q.valid &&
                 (req_addr[AW-1:2] == q.addr[AW-1:2]);

    always_comb begin
        d = q;
        if (accept) begin
            d.valid = page_en && !req_write;
            d.addr  = req_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/smc_static_ctl.sv
module smc_static_ctl
    import smc_pkg::*;
#(
    parameter int AW    = 20,
    parameter int DW    = 32,
    parameter int DLY_W = 4,
    parameter int WS_W  = 5,
    parameter int TMO_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cs_high,
    input  logic              cfg_strobe_low,
    input  logic              cfg_page_en,
    input  logic              cfg_ext_wait,
    input  logic [1:0]        cfg_width,
    input  logic [DLY_W-1:0]  cfg_we_dly,
    input  logic [DLY_W-1:0]  cfg_oe_dly,
    input  logic [WS_W-1:0]   cfg_rd_wait,
    input  logic [WS_W-1:0]   cfg_pg_wait,
    input  logic [WS_W-1:0]   cfg_wr_wait,
    input  logic [DLY_W-1:0]  cfg_turn,
    input  logic [TMO_W-1:0]  cfg_tmo,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW/8-1:0]   req_be,
    output logic              req_ack,
    output logic [DW-1:0]     rsp_rdata,
    output logic              rsp_timeout,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DW/8-1:0]   mem_bls,
    output logic [DW-1:0]     mem_dout,
    output logic              mem_dout_en,
    input  logic [DW-1:0]     mem_din,
    input  logic              mem_wait_n
);
    localparam int LANES   = DW / 8;
    localparam int CNT_W   = (WS_W > DLY_W ? WS_W : DLY_W) + 2;
    localparam int STALL_W = TMO_W + 5;

    typedef struct packed {
        smc_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [STALL_W-1:0] stall;
        logic [DLY_W-1:0]  turn_cnt;
        logic              write;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     wdata;
        logic [LANES-1:0]  be;
        logic              page;
        logic              ack;
        logic              tmo;
        logic [DW-1:0]     rdata;
    } ctl_t;

    ctl_t d, q;

    logic               acc;
    logic               accept;
    logic               page_hit;
    logic               holding;
    logic [CNT_W-1:0]   len_m1;
    logic [STALL_W-1:0] stall_lim;
    logic [DW-1:0]      lane_rd;

    smc_page_track #(.AW(AW)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .page_en   (cfg_page_en),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .hit       (page_hit)
    );

    smc_lane_map #(.LANES(LANES)) u_lanes (
        .width      (cfg_width),
        .is_write   (q.write),
        .strobe_low (cfg_strobe_low),
        .active     (acc),
        .be         (q.be),
        .din        (mem_din),
        .bls        (mem_bls),
        .rd_lanes   (lane_rd)
    );

    assign acc       = (q.st == ST_ACC);
    assign holding   = cfg_ext_wait && !mem_wait_n;
    assign stall_lim = (STALL_W'(cfg_tmo) + STALL_W'(1)) << 4;

    // last chip-select cycle index for the access in flight
    always_comb begin
        if (q.write)     len_m1 = CNT_W'(cfg_wr_wait) + CNT_W'(1);
        else if (q.page) len_m1 = CNT_W'(cfg_pg_wait);
        else             len_m1 = CNT_W'(cfg_rd_wait);
    end

    always_comb begin
        d      = q;
        d.ack  = 1'b0;
        d.tmo  = 1'b0;
        accept = 1'b0;
        case (q.st)
            ST_IDLE: accept = req_valid;
            ST_ACC: begin
                if (q.cnt != len_m1) begin
                    d.cnt = q.cnt + CNT_W'(1);
                end else if (holding && (q.stall != stall_lim)) begin
                    d.stall = q.stall + STALL_W'(1);
                end else begin
                    d.st       = ST_TURN;
                    d.turn_cnt = '0;
                    d.ack      = 1'b1;
                    d.tmo      = holding;
                    d.rdata    = q.write ? '0 : lane_rd;
                end
            end
            ST_TURN: begin
                if (q.turn_cnt == cfg_turn) begin
                    if (req_valid) accept = 1'b1;
                    else           d.st   = ST_IDLE;
                end else begin
                    d.turn_cnt = q.turn_cnt + DLY_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (accept) begin
            d.st    = ST_ACC;
            d.cnt   = '0;
            d.stall = '0;
            d.write = req_write;
            d.addr  = req_addr;
            d.wdata = req_wdata;
            d.be    = req_be;
            d.page  = page_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_cs      = cfg_cs_high ? acc : !acc;
    assign mem_oe_n    = !(acc && !q.write && (q.cnt >= CNT_W'(cfg_oe_dly)));
    assign mem_we_n    = !(acc && q.write && (q.cnt >= CNT_W'(cfg_we_dly) + CNT_W'(1)));
    assign mem_addr    = q.addr;
    assign mem_dout    = q.wdata;
    assign mem_dout_en = acc && q.write;
    assign req_ack     = q.ack;
    assign rsp_rdata   = q.rdata;
    assign rsp_timeout = q.tmo;

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    p_ack_outside_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> !acc);

    p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_tmo_with_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> req_ack);

    p_stall_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        q.stall <= stall_lim);

    p_tmo_needs_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> $past(!mem_wait_n));

    p_hold_keeps_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && holding && (q.cnt == len_m1) && (q.stall != stall_lim))
        |=> (acc && $stable(q.cnt)));

    p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> (mem_oe_n && mem_we_n && (&mem_bls)));
endmodule

// File: tb/test_smc_static_ctl.sv
`timescale 1ns/1ps
module test_smc_static_ctl;
    localparam int AW = 20;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cfg_cs_high = 0, cfg_strobe_low = 0, cfg_page_en = 0, cfg_ext_wait = 0;
    logic [1:0]  cfg_width = 2;
    logic [3:0]  cfg_we_dly = 0, cfg_oe_dly = 0, cfg_turn = 0;
    logic [4:0]  cfg_rd_wait = 0, cfg_pg_wait = 0, cfg_wr_wait = 0;
    logic [9:0]  cfg_tmo = 0;
    logic        req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ack, rsp_timeout, mem_cs, mem_oe_n, mem_we_n, mem_dout_en;
    logic [DW-1:0] rsp_rdata, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;
    logic [3:0]  mem_bls;
    logic        mem_wait_n = 1;

    smc_static_ctl #(.AW(AW), .DW(DW)) i_smc_static_ctl (
        .clk(clk), .rst_n(rst_n),
        .cfg_cs_high(cfg_cs_high), .cfg_strobe_low(cfg_strobe_low),
        .cfg_page_en(cfg_page_en), .cfg_ext_wait(cfg_ext_wait),
        .cfg_width(cfg_width), .cfg_we_dly(cfg_we_dly), .cfg_oe_dly(cfg_oe_dly),
        .cfg_rd_wait(cfg_rd_wait), .cfg_pg_wait(cfg_pg_wait), .cfg_wr_wait(cfg_wr_wait),
        .cfg_turn(cfg_turn), .cfg_tmo(cfg_tmo),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
        .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_bls(mem_bls), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_wait_n(mem_wait_n)
    );

    // device model: read data derived from the address
    assign mem_din = 32'hC3A5_0000 ^ {12'h000, mem_addr};

    int n_chk = 0;
    int n_bad = 0;

    int          r_len, r_oe, r_we, r_gap;
    logic [31:0] r_rd, r_dout;
    logic        r_den, r_tmo, r_ack_after;
    logic [3:0]  r_bls;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit cs_on();
        return cfg_cs_high ? mem_cs : !mem_cs;
    endfunction

    function automatic logic [31:0] din_of(input logic [AW-1:0] a);
        return 32'hC3A5_0000 ^ {12'h000, a};
    endfunction

    // one access from idle; measures phase positions at negedges
    task automatic run_acc(input bit wr, input logic [AW-1:0] a, input logic [31:0] wd,
                           input logic [3:0] be, input int rel_at);
        int guard;
        guard = 0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        r_len = 0; r_oe = -1; r_we = -1; r_tmo = 0; r_rd = '0; r_dout = '0; r_den = 0;
        r_bls = 4'hF;
        forever begin
            @(negedge clk);
            guard++;
            if (cs_on()) begin
                req_valid = 0;
                if (!mem_oe_n && r_oe < 0) r_oe = r_len;
                if (!mem_we_n && r_we < 0) begin
                    r_we = r_len; r_dout = mem_dout; r_den = mem_dout_en;
                end
                r_bls = mem_bls;
                r_len++;
                if (rel_at >= 0 && r_len == rel_at) mem_wait_n = 1;
            end
            if (req_ack) begin
                r_rd = rsp_rdata; r_tmo = rsp_timeout;
                break;
            end
            if (guard > 5000) begin
                chk("R1 access never acknowledged", 0, 1);
                break;
            end
        end
        req_valid = 0;
        @(negedge clk);
        r_ack_after = req_ack;
        repeat (int'(cfg_turn) + 2) @(negedge clk);
    endtask

    // two reads, second presented in the first's ack cycle; counts the idle gap
    task automatic run_gap();
        int guard;
        guard = 0;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 20'h10;
        forever begin
            @(negedge clk); guard++;
            if (cs_on()) req_valid = 0;
            if (req_ack || guard > 5000) break;
        end
        r_gap = 1;
        req_valid = 1; req_addr = 20'h20;
        forever begin
            @(negedge clk); guard++;
            if (cs_on()) begin req_valid = 0; break; end
            r_gap++;
            if (guard > 5000) break;
        end
        req_valid = 0;
        forever begin
            @(negedge clk); guard++;
            if (req_ack || guard > 5000) break;
        end
        repeat (int'(cfg_turn) + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 idle cs level", mem_cs, 1);
        chk("R1 idle oe_n", mem_oe_n, 1);
        chk("R1 idle we_n", mem_we_n, 1);
        chk("R1 idle strobes", mem_bls, 4'hF);
        chk("R1 idle ack", req_ack, 0);
    endtask

    task automatic t_reads();
        cfg_width = 2; cfg_strobe_low = 0;
        cfg_rd_wait = 3; cfg_oe_dly = 1;
        run_acc(0, 20'h00123, '0, 4'h0, -1);
        chk("R3 read length n=3", r_len, 4);
        chk("R3 oe delay n=1", r_oe, 1);
        chk("R3 no we on read", r_we, -1);
        chk("R10 read data 32-bit", r_rd, din_of(20'h00123));
        chk("R10 ack single pulse", r_ack_after, 0);
        chk("R8 read strobes style0", r_bls, 4'hF);
        cfg_rd_wait = 0; cfg_oe_dly = 0;
        run_acc(0, 20'h00040, '0, 4'h0, -1);
        chk("R3 read length n=0", r_len, 1);
        chk("R3 oe delay n=0", r_oe, 0);
    endtask

    task automatic t_writes();
        cfg_width = 2; cfg_strobe_low = 0;
        cfg_wr_wait = 1; cfg_we_dly = 0;
        run_acc(1, 20'h00077, 32'hDEAD_BEEF, 4'b0101, -1);
        chk("R4 write length n=1", r_len, 3);
        chk("R4 we delay n=0", r_we, 1);
        chk("R4 write data", r_dout, 32'hDEAD_BEEF);
        chk("R4 data drive enable", r_den, 1);
        chk("R4 no oe on write", r_oe, -1);
        chk("R9 write lane mask style0", r_bls, 4'b1010);
        cfg_wr_wait = 4; cfg_we_dly = 2;
        run_acc(1, 20'h00078, 32'h1234_5678, 4'hF, -1);
        chk("R4 write length n=4", r_len, 6);
        chk("R4 we delay n=2", r_we, 3);
        cfg_wr_wait = 0; cfg_we_dly = 0;
    endtask

    task automatic t_widths();
        cfg_rd_wait = 1; cfg_oe_dly = 0;
        cfg_width = 0; cfg_strobe_low = 0;
        run_acc(0, 20'h00201, '0, 4'h0, -1);
        chk("R9 8-bit read lanes", r_bls, 4'b0001);
        chk("R10 8-bit read data", r_rd, din_of(20'h00201) & 32'hFF);
        cfg_width = 1; cfg_strobe_low = 1;
        run_acc(0, 20'h00202, '0, 4'h0, -1);
        chk("R8 16-bit read style1", r_bls, 4'b1100);
        chk("R10 16-bit read data", r_rd, din_of(20'h00202) & 32'hFFFF);
        run_acc(1, 20'h00203, 32'h0, 4'hF, -1);
        chk("R8 16-bit write style1", r_bls, 4'b1100);
        cfg_width = 0; cfg_strobe_low = 0;
        run_acc(1, 20'h00204, 32'h0, 4'b0010, -1);
        chk("R9 enable outside width", r_bls, 4'hF);
        cfg_width = 3;
        run_acc(0, 20'h00205, '0, 4'h0, -1);
        chk("R9 reserved width no lanes", r_bls, 4'b0000);
        chk("R10 reserved width data", r_rd, 0);
        cfg_width = 2;
    endtask

    task automatic t_polarity();
        cfg_cs_high = 1; cfg_rd_wait = 2;
        @(negedge clk);
        chk("R2 idle cs active-high", mem_cs, 0);
        run_acc(0, 20'h00300, '0, 4'h0, -1);
        chk("R2 active-high cs length", r_len, 3);
        cfg_cs_high = 0;
    endtask

    task automatic t_page();
        cfg_page_en = 1; cfg_rd_wait = 5; cfg_pg_wait = 1; cfg_wr_wait = 0;
        run_acc(0, 20'h00100, '0, 4'h0, -1);
        chk("R6 first read full", r_len, 6);
        run_acc(0, 20'h00102, '0, 4'h0, -1);
        chk("R5 in-page read", r_len, 2);
        chk("R5 in-page data", r_rd, din_of(20'h00102));
        run_acc(0, 20'h00103, '0, 4'h0, -1);
        chk("R5 second in-page read", r_len, 2);
        run_acc(1, 20'h00101, 32'h5, 4'hF, -1);
        run_acc(0, 20'h00101, '0, 4'h0, -1);
        chk("R6 read after write full", r_len, 6);
        run_acc(0, 20'h00105, '0, 4'h0, -1);
        chk("R6 other group full", r_len, 6);
        cfg_page_en = 0;
        run_acc(0, 20'h00104, '0, 4'h0, -1);
        chk("R6 page disabled full", r_len, 6);
    endtask

    task automatic t_turn();
        cfg_rd_wait = 1;
        cfg_turn = 2;
        run_gap();
        chk("R7 gap turn=2", r_gap, 3);
        cfg_turn = 0;
        run_gap();
        chk("R7 gap turn=0", r_gap, 1);
    endtask

    task automatic t_wait();
        cfg_rd_wait = 2; cfg_oe_dly = 0;
        cfg_ext_wait = 1; cfg_tmo = 0;
        mem_wait_n = 0;
        run_acc(0, 20'h00400, '0, 4'h0, 5);
        chk("R11 released stretch length", r_len, 5);
        chk("R11 no timeout on release", r_tmo, 0);
        mem_wait_n = 0;
        run_acc(0, 20'h00401, '0, 4'h0, -1);
        chk("R12 timeout length n=0", r_len, 19);
        chk("R12 timeout flag", r_tmo, 1);
        cfg_tmo = 1;
        run_acc(0, 20'h00402, '0, 4'h0, -1);
        chk("R12 timeout length n=1", r_len, 35);
        cfg_ext_wait = 0;
        run_acc(0, 20'h00403, '0, 4'h0, -1);
        chk("R13 wait ignored length", r_len, 3);
        chk("R13 wait ignored flag", r_tmo, 0);
        mem_wait_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reads();
        t_writes();
        t_widths();
        t_polarity();
        t_page();
        t_turn();
        t_wait();
        @(negedge clk);
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule